// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner

This block sits between a motor-control engine and the gate drivers of a three-phase bridge. It takes six raw active-high switch commands, one high-side and one low-side per phase. It passes each through a counting noise filter and then through a per-phase guard. The guard never lets both switches of a leg conduct together, and it holds a minimum both-off gap before either switch of that leg is turned on.

Three conditions force outputs off. A global enable and a fault-disable input each force all six requests low. A per-phase high-side supply undervoltage flag blocks only that phase's high-side request. The filter length and the deadtime are parameters given in clock cycles, so the block can be retimed for any clock frequency without changing the logic.

Top module: `bridge_gate_cond`

## Requirements
- R1: Commands are active high, and bit i of each command bus belongs to phase i. A command level held for FILT_CYC consecutive clock edges is accepted. If the leg's deadtime is already satisfied, the matching output changes on the edge after the one on which the filter accepts the new level, which is FILT_CYC+1 edges after the first edge that sampled it.
- R2: A command level that holds for fewer than FILT_CYC consecutive edges is ignored, and the outputs do not change.
- R3: The high and low outputs of one phase are never high together. While both filtered commands of a phase are high, both of its outputs are low.
- R4: An output may turn on only after both outputs of its phase have been low for at least DEAD_CYC consecutive cycles. This rule applies to either side, including the side that has just turned off.
- R5: While `enable` is low, all six outputs go low on the next edge. After `enable` returns high, a phase drives again only once a fresh DEAD_CYC gap has elapsed, counted from the first edge on which the phase is enabled.
- R6: While `fault_off` is high, all six outputs go low on the next edge. Recovery follows the same deadtime rule as R5.
- R7: While `uv_hi[i]` is high, `gate_hi[i]` is low from the next edge on. The low side of that phase and the other phases are unaffected.
- R8: A synchronous active-high `rst` drives all outputs low on the next edge and clears every filter and deadtime counter. After reset is released, no output can turn on until DEAD_CYC cycles have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | PHASES | Raw high-side commands, one bit per phase |
| cmd_lo | input | PHASES | Raw low-side commands, one bit per phase |
| enable | input | 1 | Global enable; low forces all outputs off |
| fault_off | input | 1 | Fault disable; high forces all outputs off |
| uv_hi | input | PHASES | High-side supply undervoltage flag per phase |
| gate_hi | output | PHASES | High-side gate drive requests |
| gate_lo | output | PHASES | Low-side gate drive requests |

## Verification
The bench fires a pulse one cycle shorter than the filter length and one of exactly that length. A filter with an off-by-one count would either pass the short glitch or swallow the valid command. It reverses a leg's commands and samples the off gap on its last cycle and on the cycle after. A guard that counted the gap from the wrong register would turn the opposite switch on one cycle early or late. It also raises both commands of a leg, drops and restores the enable and fault inputs, and resets in the middle of operation. A design that let the conducting switch stay on, or resumed without a fresh deadtime, would show a gate request at a cycle where zero is expected. Undervoltage is raised on a leg whose low side is conducting, which exposes a design that also blocked the low side.

// File: rtl/gate_cond_pkg.sv
package gate_cond_pkg;

   // One leg's pair of switch requests.
   typedef struct packed {
      logic hi;
      logic lo;
   } leg_pair_t;

endpackage

// File: rtl/cmd_glitch_filter.sv
module cmd_glitch_filter #(
   parameter int CYC = 14
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic filt
);
   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

   generate
      if (CYC < 1) begin : g_bad
         $error("cmd_glitch_filter: CYC must be at least 1");
      end
   endgenerate

   logic level_q;

   generate
      if (CYC == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) level_q <= 1'b0;
            else     level_q <= raw;
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               level_q <= 1'b0;
               run_q   <= '0;
            end else if (raw == level_q) begin
               run_q <= '0;
            end else if (run_q == CW'(CYC - 1)) begin
               level_q <= raw;
               run_q   <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign filt = level_q;

   // R2: the filtered level only ever moves to the level the raw input carried
   assert_filter_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (filt != $past(filt))) |-> ($past(raw) == filt));

endmodule

// File: rtl/leg_guard.sv
module leg_guard
   import gate_cond_pkg::*;
#(
   parameter int DEAD_CYC = 35
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      allow,
   input  logic      uv_block,
   input  leg_pair_t want,
   output leg_pair_t drive
);
   localparam int DW = $clog2(DEAD_CYC);
   localparam logic [DW-1:0] GAP_LAST = DW'(DEAD_CYC - 1);

   generate
      if (DEAD_CYC < 2) begin : g_bad
         $error("leg_guard: DEAD_CYC must be at least 2");
      end
   endgenerate

   logic          hi_q, lo_q;
   logic [DW-1:0] gap_q;
   logic          req_hi, req_lo, gap_ok;

   always_comb begin
      req_hi = want.hi & ~want.lo & allow & ~uv_block;
      req_lo = want.lo & ~want.hi & allow;
      gap_ok = (gap_q == GAP_LAST) & ~hi_q & ~lo_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
         gap_q <= '0;
      end else begin
         hi_q <= req_hi & (hi_q | gap_ok);
         lo_q <= req_lo & (lo_q | gap_ok);
         if (!allow || hi_q || lo_q)  gap_q <= '0;
         else if (gap_q != GAP_LAST)  gap_q <= gap_q + 1'b1;
      end
   end

   assign drive.hi = hi_q;
   assign drive.lo = lo_q;

   // Independent both-off run length, used only by the deadtime check.
   localparam int RW = $clog2(DEAD_CYC + 1);
   logic [RW-1:0] off_run;
   always_ff @(posedge clk) begin
      if (rst || hi_q || lo_q)           off_run <= '0;
      else if (off_run != RW'(DEAD_CYC)) off_run <= off_run + 1'b1;
   end

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
      !(drive.hi && drive.lo));

   assert_gap_before_on_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(drive.hi) || $rose(drive.lo)) |-> (off_run >= RW'(DEAD_CYC)));

   assert_blocked_off_R5: assert property (@(posedge clk) disable iff (rst)
      !allow |=> (!drive.hi && !drive.lo));

   assert_uv_blocks_hi_R7: assert property (@(posedge clk) disable iff (rst)
      uv_block |=> !drive.hi);

endmodule

// File: rtl/bridge_gate_cond.sv
module bridge_gate_cond
   import gate_cond_pkg::*;
#(
   parameter int PHASES   = 3,
   parameter int FILT_CYC = 14,
   parameter int DEAD_CYC = 35
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PHASES-1:0] cmd_hi,
   input  logic [PHASES-1:0] cmd_lo,
   input  logic              enable,
   input  logic              fault_off,
   input  logic [PHASES-1:0] uv_hi,
   output logic [PHASES-1:0] gate_hi,
   output logic [PHASES-1:0] gate_lo
);
   generate
      if (PHASES < 1) begin : g_bad
         $error("bridge_gate_cond: PHASES must be at least 1");
      end
   endgenerate

   logic allow;
   assign allow = enable & ~fault_off;

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_leg
         leg_pair_t clean, outs;

         cmd_glitch_filter #(.CYC(FILT_CYC)) i_filt_hi (
            .clk (clk), .rst (rst), .raw (cmd_hi[p]), .filt (clean.hi)
         );
         cmd_glitch_filter #(.CYC(FILT_CYC)) i_filt_lo (
            .clk (clk), .rst (rst), .raw (cmd_lo[p]), .filt (clean.lo)
         );
         leg_guard #(.DEAD_CYC(DEAD_CYC)) i_guard (
            .clk      (clk),
            .rst      (rst),
            .allow    (allow),
            .uv_block (uv_hi[p]),
            .want     (clean),
            .drive    (outs)
         );

         assign gate_hi[p] = outs.hi;
         assign gate_lo[p] = outs.lo;
      end
   endgenerate

   assert_fault_off_R6: assert property (@(posedge clk) disable iff (rst)
      fault_off |=> (gate_hi == '0 && gate_lo == '0));

   assert_reset_off_R8: assert property (@(posedge clk)
      rst |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/test_bridge_gate_cond.sv
module test_bridge_gate_cond;
   localparam int PH = 3;
   localparam int FC = 14;
   localparam int DC = 35;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [PH-1:0] cmd_hi = '0, cmd_lo = '0, uv_hi = '0;
   logic          enable = 1'b1, fault_off = 1'b0;
   logic [PH-1:0] gate_hi, gate_lo;

   bridge_gate_cond #(.PHASES(PH), .FILT_CYC(FC), .DEAD_CYC(DC)) i_bridge_gate_cond (
      .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .enable(enable), .fault_off(fault_off), .uv_hi(uv_hi),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int            at;
      logic [PH-1:0] hi;
      logic [PH-1:0] lo;
      string         tag;
   } sb_item_t;

   sb_item_t sb[$];
   int checks = 0, bad = 0;
   bit done = 0;

   task automatic expect_at(int at, logic [PH-1:0] hi, logic [PH-1:0] lo, string tag);
      sb_item_t it;
      it.at = at; it.hi = hi; it.lo = lo; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: compares outputs against queued expectations at their cycle.
   always @(negedge clk) begin
      sb_item_t it;
      while (sb.size() != 0 && sb[0].at <= cyc) begin
         it = sb.pop_front();
         checks++;
         if (it.at != cyc || gate_hi !== it.hi || gate_lo !== it.lo) begin
            bad++;
            $display("FAIL %s cyc=%0d(at %0d) got hi=%b lo=%b expected hi=%b lo=%b",
                     it.tag, cyc, it.at, gate_hi, gate_lo, it.hi, it.lo);
         end
      end
   end

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", checks, bad);
   endtask

   initial begin
      int c;
      int d;
      expect_at(2, 3'b000, 3'b000, "R8 reset state");
      idle(3);
      rst = 1'b0;
      c = cyc;
      expect_at(c + 1, 3'b000, 3'b000, "R8 after release");
      idle(40);

      // R1: accepted high-side command on phase 0
      c = cyc; cmd_hi[0] = 1'b1;
      expect_at(c + FC,     3'b000, 3'b000, "R1 before filter done");
      expect_at(c + FC + 1, 3'b001, 3'b000, "R1 accepted");
      idle(20);

      // R2: pulse one cycle short is ignored
      c = cyc; cmd_lo[1] = 1'b1; idle(FC - 1); cmd_lo[1] = 1'b0;
      expect_at(c + 16, 3'b001, 3'b000, "R2 short pulse ignored");
      expect_at(c + 30, 3'b001, 3'b000, "R2 short pulse still ignored");
      idle(30);
      // R1: pulse of exactly the filter length passes
      c = cyc; cmd_hi[1] = 1'b1; idle(FC); cmd_hi[1] = 1'b0;
      expect_at(c + FC + 1, 3'b011, 3'b000, "R1 exact-length pulse on");
      expect_at(c + 28,     3'b011, 3'b000, "R1 exact-length pulse held");
      expect_at(c + 29,     3'b001, 3'b000, "R1 exact-length pulse off");
      idle(40);

      // R4: reverse phase 0, deadtime between hi off and lo on
      c = cyc; cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
      expect_at(c + FC,     3'b001, 3'b000, "R4 hi still on");
      expect_at(c + FC + 1, 3'b000, 3'b000, "R4 hi off");
      expect_at(c + FC + DC,     3'b000, 3'b000, "R4 last gap cycle");
      expect_at(c + FC + DC + 1, 3'b000, 3'b001, "R4 lo on after gap");
      idle(55);

      // R3: both commands high turns the conducting side off
      c = cyc; cmd_hi[0] = 1'b1;
      expect_at(c + FC,     3'b000, 3'b001, "R3 lo still on");
      expect_at(c + FC + 1, 3'b000, 3'b000, "R3 both off");
      expect_at(c + 60,     3'b000, 3'b000, "R3 both stay off");
      idle(62);
      c = cyc; cmd_hi[0] = 1'b0;
      expect_at(c + FC + 1, 3'b000, 3'b001, "R3 lo resumes");
      idle(20);

      // R5: enable low then high with fresh deadtime
      c = cyc; enable = 1'b0;
      expect_at(c + 1, 3'b000, 3'b000, "R5 enable low forces off");
      idle(10);
      d = cyc; enable = 1'b1;
      expect_at(d + DC - 1, 3'b000, 3'b000, "R5 waits fresh gap");
      expect_at(d + DC,     3'b000, 3'b001, "R5 resumes after gap");
      idle(40);

      // R6: fault disable
      c = cyc; fault_off = 1'b1;
      expect_at(c + 1, 3'b000, 3'b000, "R6 fault forces off");
      idle(10);
      d = cyc; fault_off = 1'b0;
      expect_at(d + DC - 1, 3'b000, 3'b000, "R6 waits fresh gap");
      expect_at(d + DC,     3'b000, 3'b001, "R6 resumes after gap");
      idle(40);

      // R7: undervoltage blocks only the high side
      c = cyc; cmd_hi[2] = 1'b1;
      expect_at(c + FC + 1, 3'b100, 3'b001, "R7 phase 2 hi on");
      idle(20);
      c = cyc; uv_hi[2] = 1'b1; uv_hi[0] = 1'b1;
      expect_at(c + 1,  3'b000, 3'b001, "R7 uv blocks hi, lo kept");
      expect_at(c + 10, 3'b000, 3'b001, "R7 uv still blocking");
      idle(12);

      // R8: reset in mid-run
      c = cyc; rst = 1'b1;
      expect_at(c + 1, 3'b000, 3'b000, "R8 mid-run reset");
      idle(3);
      rst = 1'b0; d = cyc;
      expect_at(d + DC - 1, 3'b000, 3'b000, "R8 gap after reset");
      expect_at(d + DC,     3'b000, 3'b001, "R8 lo back after gap");
      idle(5);

      while (sb.size() != 0) idle(1);
      idle(2);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog: run hung, got cyc=%0d expected completion", cyc);
         summary();
         $finish;
      end
   end
endmodule